// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block collects single-cycle event pulses from a display pipeline and turns them into one level-sensitive interrupt line. The five sources are end of frame for each of the two frame buffers, palette load complete, FIFO underflow and loss of sync. Each pulse latches a sticky bit in a raw status register. A separate enable register selects which sticky bits may reach the interrupt line, and a masked view of the status shows only those bits.

Software sees a small register port with a combinational read. It sets and clears enables through two separate write addresses, so no read-modify-write is needed. It clears status by writing ones, through either the raw or the masked view. When it has finished servicing, it writes the end-of-interrupt address. After the line has been raised once, it stays low for any new or remaining events until that write re-arms it. Any source still pending at that point raises the line again.

Top module: `disp_irq_stat`

## Requirements
- R1: Event input index i sets status bit P(i) on the clock edge where the pulse is sampled, with P = {0:2 sync lost, 1:5 underflow, 2:6 palette done, 3:8 end of frame 0, 4:9 end of frame 1}. A status bit stays set until it is cleared.
- R2: Writing to address 0 (raw status, read as raw status) clears every status bit whose write-data bit is 1. Writing 0xFFFF clears all pending events.
- R3: Address 1 reads raw status AND enable. A write to address 1 clears only the status bits that are both written as 1 and currently enabled.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Writing to address 2 sets the enable bits written as 1, and writing to address 3 clears the enable bits written as 1. Both addresses read back the enable register, whose bits sit at the same positions as the status bits.
- R6: When the block is armed and the masked status is non-zero, `irq` goes high on the next clock edge. It stays high while the masked status is non-zero and falls on the edge after the masked status becomes zero.
- R7: Once `irq` has asserted, it does not assert again until a write to address 4 (end of interrupt). After that write, `irq` fires again for any source still pending. Address 4 reads 0.
- R8: Reset clears the raw status and the enables, holds `irq` low and leaves the block armed.
- R9: Bits other than 2, 5, 6, 8 and 9 always read 0. Addresses 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 5 | Event pulses, one per source, indexed as in R1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach from the ports is a source that becomes pending after `irq` has already risen and fallen, while no end-of-interrupt write has been made. Here the line must stay low, and it must rise again as soon as that write arrives. A directed sequence builds this case: it clears an event, pulses the source again and only then writes end of interrupt. Random traffic then mixes event pulses, enable changes, clears through both views and end-of-interrupt writes. A cycle model in the bench predicts `irq` and the read data on every cycle. Another directed step collides an event with a clear of the same bit.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

  localparam int NUM_SRC = 5;

  // status bit position for each event source index
  function automatic int src_bit(input int idx);
    case (idx)
      0:       return 2;
      1:       return 5;
      2:       return 6;
      3:       return 8;
      default: return 9;
    endcase
  endfunction

  // mask of implemented status/enable bits
  function automatic logic [31:0] impl_mask();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[src_bit(i)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/disp_irq_src_map.sv
module disp_irq_src_map
  import disp_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [NUM_SRC-1:0] ev_pulse,
  output logic [DATA_W-1:0]  set_vec
);

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) set_vec[src_bit(i)] = ev_pulse[i];
  end

endmodule

// File: rtl/disp_irq_status_regs.sv
module disp_irq_status_regs #(
  parameter int          DATA_W = 16,
  parameter logic [31:0] IMPL   = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic [DATA_W-1:0] raw_clr,
  input  logic [DATA_W-1:0] en_set,
  input  logic [DATA_W-1:0] en_clr,
  output logic [DATA_W-1:0] raw_q,
  output logic [DATA_W-1:0] en_q
);

  localparam logic [DATA_W-1:0] KEEP = IMPL[DATA_W-1:0];

  // a new event has priority over a clear in the same cycle
  function automatic logic [DATA_W-1:0] next_raw(input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] clr,
                                                 input logic [DATA_W-1:0] set);
    return ((cur & ~clr) | set) & KEEP;
  endfunction

  function automatic logic [DATA_W-1:0] next_en(input logic [DATA_W-1:0] cur,
                                                input logic [DATA_W-1:0] s,
                                                input logic [DATA_W-1:0] c);
    return ((cur | s) & ~c) & KEEP;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= next_raw(raw_q, raw_clr, set_vec);
      en_q  <= next_en(en_q, en_set, en_clr);
    end
  end

endmodule

// File: rtl/disp_irq_gate.sv
module disp_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic eoi,
  output logic fire,
  output logic armed_q,
  output logic irq_q
);

  assign fire = armed_q & pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= fire | (irq_q & pending);
      if (eoi)       armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/disp_irq_stat.sv
module disp_irq_stat
  import disp_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] ev_pulse,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);

  localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(4);

  logic [DATA_W-1:0] set_vec, raw_clr, en_set, en_clr, raw_q, en_q, masked;
  logic              wr_raw, wr_msk, wr_set, wr_clr, wr_eoi;
  logic              fire, armed_q;

  assign wr_raw = reg_wr && (reg_addr == A_RAW);
  assign wr_msk = reg_wr && (reg_addr == A_MSK);
  assign wr_set = reg_wr && (reg_addr == A_SET);
  assign wr_clr = reg_wr && (reg_addr == A_CLR);
  assign wr_eoi = reg_wr && (reg_addr == A_EOI);

  assign raw_clr = wr_raw ? reg_wdata : (wr_msk ? (reg_wdata & en_q) : '0);
  assign en_set  = wr_set ? reg_wdata : '0;
  assign en_clr  = wr_clr ? reg_wdata : '0;
  assign masked  = raw_q & en_q;

  disp_irq_src_map #(.DATA_W(DATA_W)) u_map (
    .ev_pulse (ev_pulse),
    .set_vec  (set_vec)
  );

  disp_irq_status_regs #(.DATA_W(DATA_W), .IMPL(impl_mask())) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .raw_clr (raw_clr),
    .en_set  (en_set),
    .en_clr  (en_clr),
    .raw_q   (raw_q),
    .en_q    (en_q)
  );

  disp_irq_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (|masked),
    .eoi     (wr_eoi),
    .fire    (fire),
    .armed_q (armed_q),
    .irq_q   (irq)
  );

  always_comb begin
    case (reg_addr)
      A_RAW:        reg_rdata = raw_q;
      A_MSK:        reg_rdata = masked;
      A_SET, A_CLR: reg_rdata = en_q;
      default:      reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/disp_irq_stat_chk.sv
module disp_irq_stat_chk
  import disp_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               irq,
  input logic [DATA_W-1:0]  set_vec,
  input logic [DATA_W-1:0]  raw_q,
  input logic [DATA_W-1:0]  en_q,
  input logic               armed_q
);

  localparam logic [DATA_W-1:0] KEEP = DATA_W'(impl_mask());

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));  // R4

  AST_RAW_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0) && set_vec == '0) |=> ((raw_q & $past(reg_wdata)) == '0));  // R2

  AST_MASKED_SPARES_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(1)) |=> ((($past(raw_q) & ~$past(en_q)) & ~raw_q) == '0));  // R3

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(2)) |=> ((en_q & $past(reg_wdata & KEEP)) == $past(reg_wdata & KEEP)));  // R5

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(3)) |=> ((en_q & $past(reg_wdata)) == '0));  // R5

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((raw_q & en_q) != '0));  // R6

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(armed_q));  // R7

  AST_EOI_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(4)) |=> armed_q);  // R7

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata & ~KEEP) == '0));  // R9

endmodule

bind disp_irq_stat disp_irq_stat_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .set_vec   (set_vec),
  .raw_q     (raw_q),
  .en_q      (en_q),
  .armed_q   (armed_q)
);

// File: tb/disp_irq_stat_test.sv
module disp_irq_stat_test;

  localparam int DW = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    ev_pulse = '0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  // bench cycle model
  logic [DW-1:0] m_raw = '0, m_en = '0;
  logic          m_armed = 1'b1, m_live = 1'b0;

  always #5 clk = ~clk;

  disp_irq_stat #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [DW-1:0] BITS = 16'h0364;

  function automatic logic [DW-1:0] ev_bits(input logic [4:0] e);
    logic [DW-1:0] r = '0;
    if (e[0]) r = r | 16'h0004;
    if (e[1]) r = r | 16'h0020;
    if (e[2]) r = r | 16'h0040;
    if (e[3]) r = r | 16'h0100;
    if (e[4]) r = r | 16'h0200;
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    case (a)
      3'd0: return m_raw;
      3'd1: return m_raw & m_en;
      3'd2, 3'd3: return m_en;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] e, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string tag);
    logic [DW-1:0] clr, nraw, nen, msk;
    logic fire, nlive, narm;
    @(negedge clk);
    ev_pulse = e; reg_wr = w; reg_addr = a; reg_wdata = d;
    clr = '0;
    if (w && a == 3'd0) clr = d & BITS;
    if (w && a == 3'd1) clr = d & m_en & BITS;
    nraw = ((m_raw & ~clr) | ev_bits(e)) & BITS;
    nen = m_en;
    if (w && a == 3'd2) nen = (m_en | d) & BITS;
    if (w && a == 3'd3) nen = m_en & ~d;
    msk = m_raw & m_en;
    fire = m_armed && (msk != 0);
    nlive = fire || (m_live && (msk != 0));
    narm = (w && a == 3'd4) ? 1'b1 : (fire ? 1'b0 : m_armed);
    @(posedge clk);
    #1;
    m_raw = nraw; m_en = nen; m_live = nlive; m_armed = narm;
    check({tag, " irq"}, {15'd0, irq}, {15'd0, m_live});
    check({tag, " rdata"}, reg_rdata, exp_read(a));
  endtask

  task automatic idle(input logic [AW-1:0] a, input string tag);
    step(5'd0, 1'b0, a, '0, tag);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL R8 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    idle(3'd0, "R8 raw"); idle(3'd1, "R8 masked"); idle(3'd2, "R8 enable");
    // R1 each source lands on its own bit
    for (int i = 0; i < 5; i++) begin
      step(5'(1 << i), 1'b0, 3'd0, '0, "R1 pulse");
      idle(3'd0, "R1 hold");
    end
    // R2 clear all with 0xFFFF
    step(5'd0, 1'b1, 3'd0, 16'hFFFF, "R2 clear all");
    idle(3'd0, "R2 empty");
    // R5 enables
    step(5'd0, 1'b1, 3'd2, 16'h0360, "R5 set");
    step(5'd0, 1'b1, 3'd3, 16'h0040, "R5 clr");
    idle(3'd3, "R5 readback");
    // R3 masked view and its clear
    step(5'h1F, 1'b0, 3'd1, '0, "R3 all events");
    idle(3'd1, "R3 masked");
    step(5'd0, 1'b1, 3'd1, 16'hFFFF, "R3 masked clear");
    idle(3'd0, "R3 disabled kept");
    step(5'd0, 1'b1, 3'd0, 16'hFFFF, "R2 clear rest");
    step(5'd0, 1'b1, 3'd4, '0, "R7 rearm");
    idle(3'd4, "R7 eoi reads 0");
    // R6 timing
    step(5'b01000, 1'b0, 3'd1, '0, "R6 eof0");
    idle(3'd1, "R6 rise"); idle(3'd1, "R6 hold");
    step(5'd0, 1'b1, 3'd0, 16'h0100, "R6 clear");
    idle(3'd0, "R6 fall");
    // R7 no refire without eoi
    step(5'b01000, 1'b0, 3'd1, '0, "R7 new event");
    idle(3'd1, "R7 stays low"); idle(3'd1, "R7 stays low");
    step(5'd0, 1'b1, 3'd4, '0, "R7 eoi");
    idle(3'd1, "R7 refire"); idle(3'd1, "R7 high");
    // R4 collision: event beats clear
    step(5'b10000, 1'b1, 3'd0, 16'hFFFF, "R4 collide");
    idle(3'd0, "R4 bit kept");
    // R9 unused addresses
    step(5'd0, 1'b1, 3'd5, 16'hFFFF, "R9 addr5");
    step(5'd0, 1'b1, 3'd6, 16'hFFFF, "R9 addr6");
    step(5'd0, 1'b1, 3'd7, 16'hFFFF, "R9 addr7");
    idle(3'd0, "R9 raw intact"); idle(3'd2, "R9 enable intact");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] e;
      for (int b = 0; b < 5; b++) e[b] = ($urandom % 9) == 0;
      step(e, ($urandom % 3) == 0, AW'($urandom % 8), DW'($urandom), "R6 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule